// File: doc/BRIEF.md
# Combined Fixed-Point Divide / Square-Root / Reciprocal-Square-Root Unit

This unit computes one of three unsigned fixed-point results with a remainder, chosen by a 2-bit opcode:
- a quotient of a dividend by a divisor,
- the square root of a radicand,
- the reciprocal square root of a radicand.

All three use one digit-recurrence datapath. A start pulse, taken while the unit is idle, captures the operands and loads a left-hand compare value. Each following clock cycle resolves up to R result bits. For every candidate digit the stage forms a trial right-hand value and keeps the largest candidate that does not exceed the left-hand value. The stage then adds the chosen digit to the result, the trial value to the accumulator, and the matching term to a running product of the result and the operand.

The base width is W and the fraction width is F. The dividend is W+F bits wide with 2F fraction bits. The divisor/radicand and the result are W bits wide with F fraction bits. The remainder is 3W bits wide with 3F fraction bits and always equals the left-hand value minus the accumulator. When the exact answer needs more than W bits, the unit returns the largest W-bit value that satisfies the compare. This includes a zero divisor and a zero radicand for the reciprocal square root.

Top module: `fxp_root_div`

## Requirements
- R1: While reset is held, done, quo and rem read zero.
- R2: Opcode 2'b00 (divide), with dividend X and divisor D: quo = floor(X/D) and rem = (X − quo·D)·2^F. This holds when the quotient fits in W bits.
- R3: Opcode 2'b01 (square root), with radicand D: quo = floor(sqrt(D·2^F)) and rem = D·2^(2F) − quo²·2^F.
- R4: Opcode 2'b10 (reciprocal square root), with radicand D: quo is the largest value with quo²·D ≤ 2^(3F), and rem = 2^(3F) − quo²·D. Opcode 2'b11 gives the same results as 2'b10.
- R5: When no W-bit value reaches the exact result, quo is all ones and rem is the left-hand value minus the trial value of all ones. This covers a zero divisor and a zero reciprocal-square-root radicand, which therefore finish normally.
- R6: done is high for exactly one cycle, ceil(W/R) cycles after the edge that captured start. When R does not divide W, the last stage resolves fewer than R bits.
- R7: Operands and the opcode are taken only at the start edge. A start pulse or operand change while busy has no effect on the result.
- R8: After done, quo and rem hold their values and done stays low until the next start.
- R9: At every cycle the accumulator does not exceed the left-hand value, so rem never exceeds the loaded left-hand value. The running product always equals quo times the captured operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 2 | 00 divide, 01 square root, 10/11 reciprocal square root |
| dividend | input | W+F | Dividend, 2F fraction bits |
| operand | input | W | Divisor or radicand, F fraction bits |
| quo | output | W | Quotient or root, F fraction bits |
| rem | output | 3W | Remainder, 3F fraction bits |
| done | output | 1 | One-cycle pulse when the result is ready |

## Verification
A wrong digit choice in any stage cannot be undone later. It shows at done as a result that is either too large or one or more least-significant steps too small, and the remainder is then off by a large term. A stage that picks a digit whose trial value exceeds the left-hand value would make the remainder wrap negative. The remainder port is watched every busy cycle, so such an error is visible in the very next cycle, not only at completion. The bench runs four instances with R of 1 to 4 side by side. A fault in the step count or in the shortened last stage then appears as a latency or low-bit mismatch in only some of them.

// File: rtl/fdsr_pkg.sv
`timescale 1ns/1ps
package fdsr_pkg;
  typedef enum logic [1:0] {
    OP_DIV       = 2'b00,
    OP_SQRT      = 2'b01,
    OP_RSQRT     = 2'b10,
    OP_RSQRT_ALT = 2'b11
  } fdsr_op_e;

  // number of stages needed to resolve w bits, r per stage
  function automatic int stage_count(int w, int r);
    return (w + r - 1) / r;
  endfunction
endpackage

// File: rtl/fdsr_lhs_init.sv
`timescale 1ns/1ps
module fdsr_lhs_init
  import fdsr_pkg::*;
#(
  parameter int W = 8,
  parameter int F = 4
) (
  input  fdsr_op_e         op,
  input  logic [W+F-1:0]   dividend,
  input  logic [W-1:0]     operand,
  output logic [3*W-1:0]   lhs
);
  localparam int ACC = 3 * W;

  // left-hand compare value, aligned to 3F fraction bits
  function automatic logic [ACC-1:0] start_lhs(fdsr_op_e o,
                                               logic [W+F-1:0] x,
                                               logic [W-1:0] d);
    case (o)
      OP_DIV:  return ACC'(x) << F;
      OP_SQRT: return ACC'(d) << (2 * F);
      default: return ACC'(1) << (3 * F);
    endcase
  endfunction

  assign lhs = start_lhs(op, dividend, operand);
endmodule

// File: rtl/fdsr_digit_sel.sv
`timescale 1ns/1ps
module fdsr_digit_sel
  import fdsr_pkg::*;
#(
  parameter int W = 8,
  parameter int F = 4,
  parameter int R = 2,
  parameter int IW = $clog2(W + 1)
) (
  input  fdsr_op_e         op,
  input  logic [W-1:0]     operand,
  input  logic [W-1:0]     q,
  input  logic [2*W-1:0]   p,
  input  logic [3*W-1:0]   rhs,
  input  logic [3*W-1:0]   lhs,
  input  logic [IW-1:0]    idx,
  output logic [W-1:0]     sel_bits,
  output logic [3*W-1:0]   sel_trial,
  output logic [IW-1:0]    nidx
);
  localparam int ACC = 3 * W;
  localparam int NC  = 1 << R;

  // trial right-hand value when the shifted digit s is appended
  function automatic logic [ACC-1:0] trial_value(fdsr_op_e o,
                                                 logic [W-1:0] d,
                                                 logic [W-1:0] qv,
                                                 logic [2*W-1:0] pv,
                                                 logic [ACC-1:0] acc,
                                                 logic [ACC-1:0] s);
    logic [ACC-1:0] dd, qq, pp;
    dd = ACC'(d);
    qq = ACC'(qv);
    pp = ACC'(pv);
    case (o)
      OP_DIV:  return acc + ((dd * s) << F);
      OP_SQRT: return acc + ((qq * (s << 1)) << F) + ((s * s) << F);
      default: return acc + pp * (s << 1) + dd * s * s;
    endcase
  endfunction

  logic [IW-1:0] step;
  assign step = (idx < IW'(R)) ? idx : IW'(R);
  assign nidx = idx - step;

  logic [ACC-1:0] cand_trial [NC];
  logic [W-1:0]   cand_bits  [NC];
  logic [NC-1:0]  cand_ok;

  for (genvar g = 0; g < NC; g++) begin : g_cand
    logic [ACC-1:0] shifted;
    assign shifted       = ACC'(g) << nidx;
    assign cand_bits[g]  = W'(shifted);
    assign cand_trial[g] = trial_value(op, operand, q, p, rhs, shifted);
    // a digit is a candidate only if it fits in this stage's bit count
    assign cand_ok[g]    = ((32'(g) >> step) == 32'd0) && (cand_trial[g] <= lhs);
  end

  // largest passing digit wins; digit zero is the fallback
  always_comb begin
    sel_trial = cand_trial[0];
    sel_bits  = '0;
    for (int t = 1; t < NC; t++) begin
      if (cand_ok[t]) begin
        sel_trial = cand_trial[t];
        sel_bits  = cand_bits[t];
      end
    end
  end
endmodule

// File: rtl/fxp_root_div.sv
`timescale 1ns/1ps
module fxp_root_div
  import fdsr_pkg::*;
#(
  parameter int W = 8,
  parameter int F = 4,
  parameter int R = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [W+F-1:0]   dividend,
  input  logic [W-1:0]     operand,
  output logic [W-1:0]     quo,
  output logic [3*W-1:0]   rem,
  output logic             done
);
  localparam int ACC    = 3 * W;
  localparam int PW     = 2 * W;
  localparam int IW     = $clog2(W + 1);
  localparam int NSTAGE = stage_count(W, R);

  fdsr_op_e        op_r;
  logic [W-1:0]    d_r;
  logic [ACC-1:0]  lhs, rhs;
  logic [W-1:0]    q;
  logic [PW-1:0]   p;
  logic [IW-1:0]   idx;
  logic            busy;

  logic [ACC-1:0]  lhs_init;
  logic [W-1:0]    sel_bits;
  logic [ACC-1:0]  sel_trial;
  logic [IW-1:0]   nidx;

  // named internal events
  logic load_fire, stage_fire, last_stage;
  assign load_fire  = start && !busy;
  assign stage_fire = busy;
  assign last_stage = busy && (nidx == '0);

  fdsr_lhs_init #(.W(W), .F(F)) u_lhs (
    .op       (fdsr_op_e'(op)),
    .dividend (dividend),
    .operand  (operand),
    .lhs      (lhs_init)
  );

  fdsr_digit_sel #(.W(W), .F(F), .R(R), .IW(IW)) u_sel (
    .op        (op_r),
    .operand   (d_r),
    .q         (q),
    .p         (p),
    .rhs       (rhs),
    .lhs       (lhs),
    .idx       (idx),
    .sel_bits  (sel_bits),
    .sel_trial (sel_trial),
    .nidx      (nidx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_r <= OP_DIV;
      d_r  <= '0;
      lhs  <= '0;
      rhs  <= '0;
      q    <= '0;
      p    <= '0;
      idx  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load_fire) begin
        op_r <= fdsr_op_e'(op);
        d_r  <= operand;
        lhs  <= lhs_init;
        rhs  <= '0;
        q    <= '0;
        p    <= '0;
        idx  <= IW'(W);
        busy <= 1'b1;
      end else if (stage_fire) begin
        rhs <= sel_trial;
        q   <= q | sel_bits;
        p   <= p + PW'(d_r) * PW'(sel_bits);
        idx <= nidx;
        if (last_stage) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quo = q;
  assign rem = lhs - rhs;

  // R9
  acc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rhs <= lhs);

  // R9
  prod_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p == PW'(q) * PW'(d_r));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> ($stable(lhs) && $stable(d_r) && $stable(op_r)));

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(quo) && $stable(rem)));

  // R2
  q_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((q & $past(q)) == $past(q)));

  // R6
  stage_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IW'(W));

  // R6
  initial begin
    stage_cfg_chk: assert (NSTAGE >= 1 && R >= 1 && F <= W);
  end
endmodule

// File: tb/test_fxp_root_div.sv
`timescale 1ns/1ps
module test_fxp_root_div;
  localparam int W = 8;
  localparam int F = 4;
  localparam int NI = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op_in = 2'b00;
  logic [W+F-1:0] x_in = '0;
  logic [W-1:0] d_in = '0;
  logic [W-1:0] q_o [NI];
  logic [3*W-1:0] rem_o [NI];
  logic [NI-1:0] done_o;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  for (genvar g = 0; g < NI; g++) begin : g_r
    fxp_root_div #(.W(W), .F(F), .R(g + 1)) i_fxp_root_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .op       (op_in),
      .dividend (x_in),
      .operand  (d_in),
      .quo      (q_o[g]),
      .rem      (rem_o[g]),
      .done     (done_o[g])
    );
  end

  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] x;
    logic [7:0]  d;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 12'h0A0, 8'h10},
    '{2'd0, 12'hFFF, 8'h01},
    '{2'd0, 12'h123, 8'h07},
    '{2'd0, 12'h050, 8'h00},
    '{2'd0, 12'h000, 8'hFF},
    '{2'd1, 12'h000, 8'h40},
    '{2'd1, 12'h000, 8'hFF},
    '{2'd1, 12'h000, 8'h00},
    '{2'd1, 12'h000, 8'h03},
    '{2'd2, 12'h000, 8'h10},
    '{2'd2, 12'h000, 8'h01},
    '{2'd2, 12'h000, 8'h00},
    '{2'd2, 12'h000, 8'hC8},
    '{2'd3, 12'h000, 8'h40}
  };

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint lhs_of(input logic [1:0] o, input longint x, input longint d);
    if (o == 2'd0) return x * (longint'(1) << F);
    if (o == 2'd1) return d * (longint'(1) << (2 * F));
    return longint'(1) << (3 * F);
  endfunction

  function automatic longint rhs_of(input logic [1:0] o, input longint qv, input longint d);
    if (o == 2'd0) return qv * d * (longint'(1) << F);
    if (o == 2'd1) return qv * qv * (longint'(1) << F);
    return qv * qv * d;
  endfunction

  // largest W-bit result meeting the compare, found by downward search
  task automatic ref_calc(input logic [1:0] o, input longint x, input longint d,
                          output longint rq, output longint rr);
    longint l;
    l  = lhs_of(o, x, d);
    rq = 0;
    for (longint c = (longint'(1) << W) - 1; c >= 0; c--) begin
      if (rhs_of(o, c, d) <= l) begin
        rq = c;
        break;
      end
    end
    rr = l - rhs_of(o, rq, d);
  endtask

  task automatic run_op(input logic [1:0] o, input logic [11:0] x, input logic [7:0] d,
                        input bit garble, input string tag);
    longint eq, er, l;
    int lat [NI];
    logic [W-1:0] cq [NI];
    logic [3*W-1:0] cr [NI];
    ref_calc(o, longint'(x), longint'(d), eq, er);
    l = lhs_of(o, longint'(x), longint'(d));
    for (int k = 0; k < NI; k++) begin
      lat[k] = 0;
      cq[k] = '0;
      cr[k] = '0;
    end
    @(negedge clk);
    op_in = o; x_in = x; d_in = d; start = 1'b1;
    @(negedge clk);
    if (garble) begin
      op_in = ~o; x_in = ~x; d_in = ~d;
    end else begin
      start = 1'b0;
    end
    for (int c = 1; c <= 10; c++) begin
      @(negedge clk);
      if (c == 1) start = 1'b0;
      for (int k = 0; k < NI; k++) begin
        if (done_o[k] && lat[k] == 0) begin
          lat[k] = c;
          cq[k] = q_o[k];
          cr[k] = rem_o[k];
        end
        chk("R9 rem within lhs", longint'(rem_o[k] <= l[3*W-1:0]), 1);
      end
    end
    for (int k = 0; k < NI; k++) begin
      chk("R6 latency", lat[k], (W + k) / (k + 1));
      chk({tag, " quo"}, longint'(cq[k]), eq);
      chk({tag, " rem"}, longint'(cr[k]), er);
      chk("R8 quo held", longint'(q_o[k]), longint'(cq[k]));
      chk("R8 rem held", longint'(rem_o[k]), longint'(cr[k]));
      chk("R8 done low", longint'(done_o[k]), 0);
    end
  endtask

  initial begin
    #(20 * 60000);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog R6 actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int k = 0; k < NI; k++) begin
      chk("R1 done", longint'(done_o[k]), 0);
      chk("R1 quo", longint'(q_o[k]), 0);
      chk("R1 rem", longint'(rem_o[k]), 0);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      longint eq, er;
      string t;
      ref_calc(VECS[v].op, longint'(VECS[v].x), longint'(VECS[v].d), eq, er);
      if (eq == (longint'(1) << W) - 1) t = "R5";
      else if (VECS[v].op == 2'd0) t = "R2";
      else if (VECS[v].op == 2'd1) t = "R3";
      else t = "R4";
      run_op(VECS[v].op, VECS[v].x, VECS[v].d, 1'b0, t);
    end

    // start held through the first stage with garbled operands
    run_op(2'd0, 12'h0A0, 8'h10, 1'b1, "R7");
    run_op(2'd1, 12'h000, 8'h40, 1'b1, "R7");

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule